// File: doc/BRIEF.md
# PWM Action Qualifier with Shadowed Software Force

This block turns time-base events into two PWM output levels, A and B. A time base, outside this block, supplies a tick enable plus four event strobes: counter at zero, counter at period, counter equal to compare A while counting up, and counter equal to compare B while counting up. On each tick, every channel looks up a 2-bit action for each event that is present in its own control register. The highest-priority non-idle action is applied to that channel's output flop.

A continuous software-force value can pin either output low or high. Software writes the force value into a shadow register. The shadow is copied into the active force register at a reload point chosen by a separate reload-mode field. That reload point can be counter zero, counter period, either of the two, or the next tick. While an active force code is in effect, it takes precedence over all event actions.

All registers are written through a simple write port. There is no read-back path.

Top module: `pwm_action_qual`

## Requirements
- R1: After reset, both outputs are low, every action code is 0 and both force codes (shadow and active) are 0.
- R2: Action codes are: 0 = leave the output unchanged, 1 = drive low, 2 = drive high, 3 = invert. The chosen code is applied at the clock edge of a cycle with `tick_i` high.
- R3: Writes go to these byte offsets:
  - 0x16: channel A action control.
  - 0x18: channel B action control.
  - 0x1A: force reload mode.
  - 0x1C: force shadow.
  
  Within an action control word, the zero event uses bits [1:0], the period event bits [3:2], compare A up bits [5:4] and compare B up bits [9:8].
- R4: When several events are present on one tick, the channel applies the code of the highest-priority event whose code is not 0. From highest to lowest, the priority is compare B, compare A, period, zero.
- R5: Event strobes in a cycle with `tick_i` low change neither output.
- R6: In the force word, channel A's code is bits [1:0] and channel B's code is bits [3:2]. Code 1 forces low, code 2 forces high, and codes 0 and 3 apply no override.
- R7: On a tick where a channel's active force code is 1 or 2, the output takes the forced level whatever events are present.
- R8: The reload mode is bits [7:6] of the word at 0x1A. Mode 0 copies the shadow to the active force register on a tick with the zero event. Mode 1 copies on a tick with the period event. Mode 2 copies on a tick with either event. Mode 3 copies on every tick, so a force written in an earlier cycle governs the output from the next tick.
- R9: A force value written to the shadow has no effect on the outputs until its reload point occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base tick enable |
| zero_i | input | 1 | Counter-at-zero event |
| period_i | input | 1 | Counter-at-period event |
| cmpa_up_i | input | 1 | Compare A match while counting up |
| cmpb_up_i | input | 1 | Compare B match while counting up |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register byte offset |
| wr_data_i | input | 10 | Register write data |
| out_a_o | output | 1 | PWM output A |
| out_b_o | output | 1 | PWM output B |

## Verification
Two pairs of functions can land on the same clock edge:
- A force reload and an event action: the same zero or period strobe both copies the shadow and carries its own action code.
- Several events on one tick: they compete for the output.

The stimulus provokes both pairs. Directed ticks assert all four strobes at once under chosen codes. Seeded random ticks mix random event sets with random writes to the control, reload-mode and force registers.

A bench model judges each output after every step. It reloads the force first, then picks the forced level or the winning event code.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 10;
  localparam int NCH      = 2;
  localparam int CODE_W   = 2;

  localparam logic [ADDR_W-1:0] OFS_CTL_BASE = 8'h16;  // channel n at base + 2n
  localparam logic [ADDR_W-1:0] OFS_RLD      = 8'h1A;
  localparam logic [ADDR_W-1:0] OFS_FRC      = 8'h1C;

  localparam int ZRO_LSB  = 0;
  localparam int PRD_LSB  = 2;
  localparam int CMPA_LSB = 4;
  localparam int CMPB_LSB = 8;
  localparam int RLD_LSB  = 6;

  typedef enum logic [CODE_W-1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    RLD_ZERO   = 2'd0,
    RLD_PERIOD = 2'd1,
    RLD_EITHER = 2'd2,
    RLD_NOW    = 2'd3
  } rld_e;

  typedef struct packed {
    act_e cmpb;
    act_e cmpa;
    act_e prd;
    act_e zro;
  } ctl_t;

  typedef struct packed {
    logic cmpb;
    logic cmpa;
    logic prd;
    logic zro;
  } evt_t;
endpackage

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
  import pwm_aq_pkg::*;
#(
  parameter int N  = NCH,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [DW-1:0]        wr_data_i,
  output ctl_t [N-1:0]         ctl_o,
  output rld_e                 rld_o,
  output logic [N*CODE_W-1:0]  frc_shadow_o
);
  localparam int FW = N * CODE_W;

  for (genvar ch = 0; ch < N; ch++) begin : g_ctl
    localparam logic [AW-1:0] OFS = AW'(OFS_CTL_BASE + 2 * ch);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_o[ch] <= '0;
      end else if (wr_en_i && wr_addr_i == OFS) begin
        ctl_o[ch].zro  <= act_e'(wr_data_i[ZRO_LSB  +: CODE_W]);
        ctl_o[ch].prd  <= act_e'(wr_data_i[PRD_LSB  +: CODE_W]);
        ctl_o[ch].cmpa <= act_e'(wr_data_i[CMPA_LSB +: CODE_W]);
        ctl_o[ch].cmpb <= act_e'(wr_data_i[CMPB_LSB +: CODE_W]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_o        <= RLD_ZERO;
      frc_shadow_o <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == OFS_RLD) rld_o        <= rld_e'(wr_data_i[RLD_LSB +: 2]);
      if (wr_addr_i == OFS_FRC) frc_shadow_o <= wr_data_i[FW-1:0];
    end
  end
endmodule

// File: rtl/pwm_aq_force.sv
module pwm_aq_force
  import pwm_aq_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  evt_t                evt_i,
  input  rld_e                rld_i,
  input  logic [N*CODE_W-1:0] shadow_i,
  output logic [N*CODE_W-1:0] frc_nxt_o,
  output logic [N*CODE_W-1:0] frc_q_o
);
  logic load;

  always_comb begin
    unique case (rld_i)
      RLD_ZERO:   load = evt_i.zro;
      RLD_PERIOD: load = evt_i.prd;
      RLD_EITHER: load = evt_i.zro | evt_i.prd;
      default:    load = 1'b1;
    endcase
    load      = load & tick_i;
    frc_nxt_o = load ? shadow_i : frc_q_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frc_q_o <= '0;
    else         frc_q_o <= frc_nxt_o;
  end
endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
  import pwm_aq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  evt_t              evt_i,
  input  ctl_t              ctl_i,
  input  logic [CODE_W-1:0] frc_i,
  output logic              out_o
);
  act_e act;
  logic out_d;

  // Highest-priority present event with a non-idle code wins.
  always_comb begin
    act = ACT_NONE;
    if      (evt_i.cmpb && ctl_i.cmpb != ACT_NONE) act = ctl_i.cmpb;
    else if (evt_i.cmpa && ctl_i.cmpa != ACT_NONE) act = ctl_i.cmpa;
    else if (evt_i.prd  && ctl_i.prd  != ACT_NONE) act = ctl_i.prd;
    else if (evt_i.zro  && ctl_i.zro  != ACT_NONE) act = ctl_i.zro;
  end

  always_comb begin
    out_d = out_o;
    if (tick_i) begin
      if      (frc_i == 2'd1) out_d = 1'b0;
      else if (frc_i == 2'd2) out_d = 1'b1;
      else begin
        unique case (act)
          ACT_LOW:    out_d = 1'b0;
          ACT_HIGH:   out_d = 1'b1;
          ACT_TOGGLE: out_d = ~out_o;
          default:    out_d = out_o;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_o <= 1'b0;
    else         out_o <= out_d;
  end
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwm_aq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          zero_i,
  input  logic          period_i,
  input  logic          cmpa_up_i,
  input  logic          cmpb_up_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          out_a_o,
  output logic          out_b_o
);
  localparam int FW = NCH * CODE_W;

  evt_t             evt;
  ctl_t [NCH-1:0]   ctl_q;
  rld_e             rld_q;
  logic [FW-1:0]    frc_shadow_q;
  logic [FW-1:0]    frc_nxt;
  logic [FW-1:0]    frc_q;
  logic [NCH-1:0]   pwm_q;

  assign evt = '{cmpb: cmpb_up_i, cmpa: cmpa_up_i, prd: period_i, zro: zero_i};

  pwm_aq_regs #(.N(NCH), .AW(AW), .DW(DW)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .ctl_o        (ctl_q),
    .rld_o        (rld_q),
    .frc_shadow_o (frc_shadow_q)
  );

  pwm_aq_force #(.N(NCH)) u_force (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .evt_i     (evt),
    .rld_i     (rld_q),
    .shadow_i  (frc_shadow_q),
    .frc_nxt_o (frc_nxt),
    .frc_q_o   (frc_q)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    pwm_aq_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .evt_i  (evt),
      .ctl_i  (ctl_q[ch]),
      .frc_i  (frc_nxt[ch*CODE_W +: CODE_W]),
      .out_o  (pwm_q[ch])
    );
  end

  assign out_a_o = pwm_q[0];
  assign out_b_o = pwm_q[1];
endmodule

// File: rtl/pwm_aq_chk.sv
module pwm_aq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       zero_i,
  input logic       period_i,
  input logic       cmpa_up_i,
  input logic       cmpb_up_i,
  input logic       out_a_o,
  input logic       out_b_o,
  input logic [3:0] frc_act,
  input logic [1:0] rld_mode
);
  logic any_evt;
  assign any_evt = zero_i | period_i | cmpa_up_i | cmpb_up_i;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(out_a_o) && $stable(out_b_o)); // R5

  AST_FORCE_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (frc_act[1:0] != 2'd1 || !out_a_o) && (frc_act[1:0] != 2'd2 || out_a_o)); // R7

  AST_FORCE_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (frc_act[3:2] != 2'd1 || !out_b_o) && (frc_act[3:2] != 2'd2 || out_b_o)); // R7

  AST_SHADOW_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i || (!any_evt && rld_mode != 2'd3)) |=> $stable(frc_act)); // R8

  AST_NO_EVT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !any_evt && rld_mode != 2'd3) |=>
      (frc_act[1:0] == 2'd1 || frc_act[1:0] == 2'd2 || $stable(out_a_o))); // R4
endmodule

bind pwm_action_qual pwm_aq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .zero_i    (zero_i),
  .period_i  (period_i),
  .cmpa_up_i (cmpa_up_i),
  .cmpb_up_i (cmpb_up_i),
  .out_a_o   (out_a_o),
  .out_b_o   (out_b_o),
  .frc_act   (frc_q),
  .rld_mode  (rld_q)
);

// File: tb/pwm_action_qual_tb_top.sv
module pwm_action_qual_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, z = 1'b0, p = 1'b0, ca = 1'b0, cb = 1'b0;
  logic       wen = 1'b0;
  logic [7:0] waddr = '0;
  logic [9:0] wdata = '0;
  logic       out_a, out_b;

  int n_chk = 0;
  int n_bad = 0;

  // bench reference state
  logic [9:0] m_ctl_a = '0, m_ctl_b = '0;
  logic [1:0] m_rld = '0;
  logic [3:0] m_shadow = '0, m_force = '0;
  logic       m_a = 1'b0, m_b = 1'b0;

  always #5 clk = ~clk;

  pwm_action_qual dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .zero_i    (z),
    .period_i  (p),
    .cmpa_up_i (ca),
    .cmpb_up_i (cb),
    .wr_en_i   (wen),
    .wr_addr_i (waddr),
    .wr_data_i (wdata),
    .out_a_o   (out_a),
    .out_b_o   (out_b)
  );

  function automatic logic [1:0] pick(logic [9:0] c, logic ez, logic ep, logic ea, logic eb);
    if (eb && c[9:8] != 0) return c[9:8];
    if (ea && c[5:4] != 0) return c[5:4];
    if (ep && c[3:2] != 0) return c[3:2];
    if (ez && c[1:0] != 0) return c[1:0];
    return 2'd0;
  endfunction

  function automatic logic next_out(logic cur, logic [1:0] frc, logic [1:0] act);
    if (frc == 2'd1) return 1'b0;
    if (frc == 2'd2) return 1'b1;
    case (act)
      2'd1: return 1'b0;
      2'd2: return 1'b1;
      2'd3: return ~cur;
      default: return cur;
    endcase
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_both(string req);
    chk(req, out_a, m_a);
    chk(req, out_b, m_b);
  endtask

  // R3: offsets 0x16 / 0x18 / 0x1A / 0x1C
  task automatic wr(logic [7:0] a, logic [9:0] d);
    @(negedge clk);
    {tick, z, p, ca, cb} = '0;
    wen = 1'b1; waddr = a; wdata = d;
    @(posedge clk);
    case (a)
      8'h16: m_ctl_a = d;
      8'h18: m_ctl_b = d;
      8'h1A: m_rld = d[7:6];
      8'h1C: m_shadow = d[3:0];
      default: ;
    endcase
    #2;
  endtask

  task automatic step(logic t, logic ez, logic ep, logic ea, logic eb);
    logic ld;
    @(negedge clk);
    wen = 1'b0;
    tick = t; z = ez; p = ep; ca = ea; cb = eb;
    @(posedge clk);
    if (t) begin
      ld = (m_rld == 2'd3) || (m_rld == 2'd0 && ez) || (m_rld == 2'd1 && ep) ||
           (m_rld == 2'd2 && (ez || ep));
      if (ld) m_force = m_shadow;
      m_a = next_out(m_a, m_force[1:0], pick(m_ctl_a, ez, ep, ea, eb));
      m_b = next_out(m_b, m_force[3:2], pick(m_ctl_b, ez, ep, ea, eb));
    end
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    #2;
    chk_both("R1 reset");
    @(negedge clk) rst_n = 1'b1;
    step(1, 1, 1, 1, 1);
    chk_both("R1 codes cleared");

    // R2 codes on zero event
    wr(8'h16, 10'h002);
    step(1, 1, 0, 0, 0); chk("R2 high", out_a, 1'b1);
    wr(8'h16, 10'h003);
    step(1, 1, 0, 0, 0); chk("R2 toggle", out_a, 1'b0);
    step(1, 1, 0, 0, 0); chk("R2 toggle", out_a, 1'b1);
    wr(8'h16, 10'h001);
    step(1, 1, 0, 0, 0); chk("R2 low", out_a, 1'b0);
    wr(8'h16, 10'h000);
    step(1, 1, 0, 0, 0); chk("R2 none", out_a, 1'b0);

    // R5 strobes without tick
    wr(8'h16, 10'h0FF);
    step(0, 1, 1, 1, 1); chk("R5 no tick", out_a, 1'b0);

    // R4 priority: cb low, ca high, prd low, zro high
    wr(8'h18, 10'h0_6 | (10'h1 << 8) | (10'h2 << 4)); // B: cb=1 ca=2 prd=1 zro=2
    wr(8'h16, (10'h1 << 8) | (10'h2 << 4) | (10'h1 << 2) | 10'h2);
    step(1, 0, 0, 1, 0); chk("R4 ca alone", out_a, 1'b1);
    step(1, 1, 1, 1, 1); chk("R4 cb wins", out_a, 1'b0);
    chk_both("R4 both");
    wr(8'h16, (10'h2 << 4) | (10'h1 << 2) | 10'h2);
    step(1, 1, 1, 1, 1); chk("R4 idle cb skipped", out_a, 1'b1);
    wr(8'h16, (10'h1 << 2) | 10'h2);
    step(1, 1, 1, 0, 0); chk("R4 prd over zro", out_a, 1'b0);

    // R6/R9 force shadow, reload at zero (mode 0)
    wr(8'h16, 10'h003);
    wr(8'h1C, 10'h0E); // A high, B code 3 none
    step(1, 0, 1, 0, 0); chk_both("R9 not yet loaded");
    step(1, 1, 0, 0, 0); chk("R6 force high A", out_a, 1'b1);
    chk_both("R6 B code3 none");
    step(1, 1, 0, 0, 0); chk("R7 force beats toggle", out_a, 1'b1);
    wr(8'h1C, 10'h04); // B low
    step(1, 1, 0, 0, 0); chk("R6 force low B", out_b, 1'b0);

    // R8 mode 1 period
    wr(8'h1A, 10'h1 << 6);
    wr(8'h1C, 10'h01);
    step(1, 1, 0, 0, 0); chk("R8 period mode waits", out_a, m_a);
    step(1, 0, 1, 0, 0); chk("R8 period load", out_a, 1'b0);
    // mode 2 either
    wr(8'h1A, 10'h2 << 6);
    wr(8'h1C, 10'h02);
    step(1, 0, 0, 1, 0); chk("R8 either waits", out_a, 1'b0);
    step(1, 1, 0, 0, 0); chk("R8 either load", out_a, 1'b1);
    // mode 3 immediate
    wr(8'h1A, 10'h3 << 6);
    wr(8'h1C, 10'h05);
    step(0, 0, 0, 0, 0); chk("R8 waits for tick", out_a, 1'b1);
    step(1, 0, 0, 0, 0); chk("R8 immediate", out_a, 1'b0);
    chk_both("R8 immediate both");

    // seeded random mix
    for (int i = 0; i < 1500; i++) begin
      int unsigned r;
      r = $urandom % 10;
      if (r == 0) begin
        int unsigned k;
        logic [7:0] adr;
        k = $urandom % 5;
        adr = (k == 4) ? 8'h12 : 8'h16 + 8'(2 * k);
        wr(adr, 10'($urandom));
      end else begin
        step(($urandom % 4) != 0, $urandom % 3 == 0, $urandom % 3 == 0,
             $urandom % 3 == 0, $urandom % 3 == 0);
      end
      chk_both("R4 R7 R8 random");
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule